// File: doc/BRIEF.md
# SPI FIFO Transfer-Level Controller

This block sits beside the receive and transmit FIFOs of one SPI channel and decides when to ask for service. It holds one 32-bit control word made of three fields: a word count and two FIFO level codes. From the FIFO byte occupancy it raises a receive request when enough bytes are waiting to be read, and a transmit request when enough free space is available to be written. Either request can drive an interrupt or a DMA engine.

The same block counts SPI words as the shift engine finishes them. When a nonzero count is programmed and a transfer is started, the count field reads back the live word index. The block then gives a one-cycle end pulse when the index reaches the count. A count of zero turns counting off. Level codes use an n-1 encoding, so code k stands for k+1 bytes.

Top module: `spi_lvl_ctrl`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 0 and `rx_req`, `tx_req`, `xfer_end` and `xfer_active` are all low.
- R2: The control word packs the word count into bits 31:16, the receive level code into bits 15:8 and the transmit level code into bits 7:0. When no transfer has been started since the last idle write, `reg_rdata` returns the last value written.
- R3: `rx_req` is registered. One cycle after `rx_en` is high and `rx_occ` is at least the receive threshold, it is high. It falls one cycle after occupancy drops below the threshold. The threshold is code+1 bytes.
- R4: `tx_req` is registered. One cycle after `tx_en` is high and the free space (16 − `tx_occ`) is at least code+1 bytes, it is high.
- R5: A level code above 15 is treated as 16 bytes.
- R6: While `rx_en` is low, `rx_req` is low one cycle later. The same holds for `tx_en` and `tx_req`.
- R7: With a word count of 0, `xfer_start` does not start a transfer. `xfer_active` stays low, the count field keeps reading 0 and `xfer_end` never pulses.
- R8: With a nonzero count, the cycle after `xfer_start` raises `xfer_active`. From then on, bits 31:16 read the word index: 0 at first, then one more after each `word_done` pulse.
- R9: The `word_done` pulse that brings the index up to the count gives a `xfer_end` pulse of exactly one cycle in the following cycle, and `xfer_active` drops at the same time. Later `word_done` pulses leave the index unchanged.
- R10: A write while a transfer is active does not change the stored count. The two level codes still take the new value.
- R11: Every `xfer_start`, including one during an active transfer, sets the index to 0.
- R12: A write while idle makes the count field read back the programmed value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data (index in place of the count once started) |
| xfer_start | input | 1 | Transfer start pulse |
| word_done | input | 1 | One pulse per completed SPI word |
| rx_en | input | 1 | Receive direction enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_occ | input | 5 | Receive FIFO bytes held (0..16) |
| tx_occ | input | 5 | Transmit FIFO bytes held (0..16) |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| xfer_end | output | 1 | One-cycle end-of-transfer pulse |
| xfer_active | output | 1 | Counted transfer in progress |

## Verification
The bench builds the block with its default widths: a 16-bit count, 8-bit level codes and a 16-byte FIFO depth. The FIFO is small, so every level code from 0 through 20 is swept against every occupancy from 0 through 16 in both directions. This covers the exact threshold boundaries and the clamping of codes above 15, with and without the direction enables. A short count of five words exercises the index readback, the end pulse, the ignored write during a transfer and a restart in the middle of a transfer.

// File: rtl/spi_lvl_pkg.sv
package spi_lvl_pkg;

    parameter int CNT_W      = 16;
    parameter int LVL_W      = 8;
    parameter int FIFO_DEPTH = 16;
    parameter int OCC_W      = $clog2(FIFO_DEPTH + 1);
    parameter int REG_W      = CNT_W + 2 * LVL_W;

    typedef struct packed {
        logic [CNT_W-1:0] wcount;
        logic [LVL_W-1:0] rx_code;
        logic [LVL_W-1:0] tx_code;
    } lvl_cfg_t;

    typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

    // n-1 coded level, clamped to the FIFO depth
    function automatic int lvl_bytes(input logic [LVL_W-1:0] code);
        if (int'(code) >= FIFO_DEPTH)
            return FIFO_DEPTH;
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/spi_lvl_regs.sv
module spi_lvl_regs
    import spi_lvl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    input  logic             start,
    output lvl_cfg_t         cfg,
    output logic             idle_wr
);

    lvl_cfg_t cfg_q;
    lvl_cfg_t wr_word;

    assign wr_word = lvl_cfg_t'(wdata);
    assign idle_wr = wr_en && !busy && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.rx_code <= wr_word.rx_code;
            cfg_q.tx_code <= wr_word.tx_code;
            if (idle_wr)
                cfg_q.wcount <= wr_word.wcount;
        end
    end

    assign cfg = cfg_q;

    p_cnt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q.wcount));

endmodule

// File: rtl/spi_lvl_thresh.sv
module spi_lvl_thresh
    import spi_lvl_pkg::*;
#(
    parameter dir_e DIR   = DIR_RX,
    parameter int   DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [OCC_W-1:0] occ,
    input  logic [LVL_W-1:0] code,
    output logic             req
);

    logic hit;
    logic req_q;

    generate
        if (DIR == DIR_RX) begin : g_rx
            always_comb hit = int'(occ) >= lvl_bytes(code);
        end else begin : g_tx
            always_comb hit = (DEPTH - int'(occ)) >= lvl_bytes(code);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= en && hit;
    end

    assign req = req_q;

    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !req);

    generate
        if (DIR == DIR_RX) begin : g_a_rx
            p_full_req_r3: assert property (@(posedge clk) disable iff (rst)
                (en && int'(occ) >= DEPTH) |=> req);
        end else begin : g_a_tx
            p_empty_req_r4: assert property (@(posedge clk) disable iff (rst)
                (en && occ == '0) |=> req);
        end
    endgenerate

endmodule

// File: rtl/spi_lvl_count.sv
module spi_lvl_count
    import spi_lvl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             word_done,
    input  logic             idle_wr,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] idx,
    output logic             active,
    output logic             started,
    output logic             done_pulse
);

    logic [CNT_W-1:0] idx_q, idx_nxt;
    logic             act_q, strt_q, end_q;

    assign idx_nxt = idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            act_q  <= 1'b0;
            strt_q <= 1'b0;
            end_q  <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (start) begin
                idx_q  <= '0;
                act_q  <= (target != '0);
                strt_q <= (target != '0);
            end else begin
                if (idle_wr)
                    strt_q <= 1'b0;
                if (act_q && word_done) begin
                    idx_q <= idx_nxt;
                    if (idx_nxt == target) begin
                        act_q <= 1'b0;
                        end_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign idx        = idx_q;
    assign active     = act_q;
    assign started    = strt_q;
    assign done_pulse = end_q;

    p_idx_below_r8: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (idx_q < target));
    p_end_single_r9: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);
    p_end_at_count_r9: assert property (@(posedge clk) disable iff (rst)
        end_q |-> (idx_q == target && !act_q));
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (start && target == '0) |=> !act_q);

endmodule

// File: rtl/spi_lvl_ctrl.sv
module spi_lvl_ctrl
    import spi_lvl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             xfer_start,
    input  logic             word_done,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [OCC_W-1:0] rx_occ,
    input  logic [OCC_W-1:0] tx_occ,
    output logic             rx_req,
    output logic             tx_req,
    output logic             xfer_end,
    output logic             xfer_active
);

    lvl_cfg_t         cfg;
    lvl_cfg_t         view;
    logic             idle_wr;
    logic             started;
    logic [CNT_W-1:0] idx;

    spi_lvl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .busy    (xfer_active),
        .start   (xfer_start),
        .cfg     (cfg),
        .idle_wr (idle_wr)
    );

    spi_lvl_count u_count (
        .clk        (clk),
        .rst        (rst),
        .start      (xfer_start),
        .word_done  (word_done),
        .idle_wr    (idle_wr),
        .target     (cfg.wcount),
        .idx        (idx),
        .active     (xfer_active),
        .started    (started),
        .done_pulse (xfer_end)
    );

    spi_lvl_thresh #(.DIR(DIR_RX), .DEPTH(FIFO_DEPTH)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en),
        .occ  (rx_occ),
        .code (cfg.rx_code),
        .req  (rx_req)
    );

    spi_lvl_thresh #(.DIR(DIR_TX), .DEPTH(FIFO_DEPTH)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .en   (tx_en),
        .occ  (tx_occ),
        .code (cfg.tx_code),
        .req  (tx_req)
    );

    always_comb begin
        view = cfg;
        if (started)
            view.wcount = idx;
    end

    assign reg_rdata = view;

endmodule

// File: tb/spi_lvl_ctrl_test.sv
module spi_lvl_ctrl_test;
    import spi_lvl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr_en = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             xfer_start = 1'b0;
    logic             word_done = 1'b0;
    logic             rx_en = 1'b0;
    logic             tx_en = 1'b0;
    logic [OCC_W-1:0] rx_occ = '0;
    logic [OCC_W-1:0] tx_occ = '0;
    logic             rx_req, tx_req, xfer_end, xfer_active;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_lvl_ctrl uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_start(xfer_start), .word_done(word_done),
        .rx_en(rx_en), .tx_en(tx_en), .rx_occ(rx_occ), .tx_occ(tx_occ),
        .rx_req(rx_req), .tx_req(tx_req),
        .xfer_end(xfer_end), .xfer_active(xfer_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock edge; return at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] cnt, input logic [7:0] rxc, input logic [7:0] txc);
        reg_wdata = {cnt, rxc, txc};
        reg_wr_en = 1'b1;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic start_pulse();
        xfer_start = 1'b1;
        step();
        xfer_start = 1'b0;
    endtask

    task automatic word_pulse();
        word_done = 1'b1;
        step();
        word_done = 1'b0;
    endtask

    function automatic int exp_bytes(input int code);
        return (code > 15) ? 16 : code + 1;
    endfunction

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 outs", {28'h0, rx_req, tx_req, xfer_end, xfer_active}, 32'h0);

        // R2 field layout readback
        wr(16'hA5C3, 8'h3E, 8'h71);
        chk("R2 readback", reg_rdata, 32'hA5C3_3E71);
        chk("R2 count field", {16'h0, reg_rdata[31:16]}, 32'hA5C3);
        chk("R2 rx field", {24'h0, reg_rdata[15:8]}, 32'h3E);
        chk("R2 tx field", {24'h0, reg_rdata[7:0]}, 32'h71);

        // R3 R4 R5 sweep of codes and occupancy, enables on
        rx_en = 1'b1;
        tx_en = 1'b1;
        for (int code = 0; code <= 20; code++) begin
            wr(16'h0, 8'(code), 8'(code));
            for (int occ = 0; occ <= 16; occ++) begin
                rx_occ = 5'(occ);
                tx_occ = 5'(occ);
                step();
                chk(code > 15 ? "R5 rx clamp" : "R3 rx level", {31'h0, rx_req},
                    {31'h0, occ >= exp_bytes(code)});
                chk(code > 15 ? "R5 tx clamp" : "R4 tx level", {31'h0, tx_req},
                    {31'h0, (16 - occ) >= exp_bytes(code)});
            end
        end

        // R3 drop one cycle after occupancy falls below threshold
        wr(16'h0, 8'd7, 8'd0);
        rx_occ = 5'd8;
        step();
        chk("R3 held", {31'h0, rx_req}, 32'h1);
        rx_occ = 5'd7;
        step();
        chk("R3 fall", {31'h0, rx_req}, 32'h0);

        // R6 enables gate requests
        rx_en = 1'b0;
        tx_en = 1'b0;
        for (int occ = 0; occ <= 16; occ++) begin
            rx_occ = 5'(occ);
            tx_occ = 5'(occ);
            step();
            chk("R6 rx gated", {31'h0, rx_req}, 32'h0);
            chk("R6 tx gated", {31'h0, tx_req}, 32'h0);
        end
        rx_occ = 5'd16;
        tx_occ = 5'd0;
        rx_en = 1'b1;
        step();
        chk("R6 rx only", {30'h0, rx_req, tx_req}, 32'h2);
        rx_en = 1'b0;
        tx_en = 1'b1;
        step();
        chk("R6 tx only", {30'h0, rx_req, tx_req}, 32'h1);
        tx_en = 1'b0;

        // R7 zero count disables counting
        wr(16'h0, 8'h01, 8'h02);
        start_pulse();
        chk("R7 not active", {31'h0, xfer_active}, 32'h0);
        word_pulse();
        chk("R7 count reads 0", reg_rdata, 32'h0000_0102);
        chk("R7 no end", {31'h0, xfer_end}, 32'h0);

        // R8 index readback
        wr(16'd5, 8'h01, 8'h02);
        chk("R12 programmed", {16'h0, reg_rdata[31:16]}, 32'd5);
        start_pulse();
        chk("R8 active", {31'h0, xfer_active}, 32'h1);
        chk("R8 index 0", {16'h0, reg_rdata[31:16]}, 32'd0);
        word_pulse();
        chk("R8 index 1", {16'h0, reg_rdata[31:16]}, 32'd1);
        word_pulse();
        chk("R8 index 2", {16'h0, reg_rdata[31:16]}, 32'd2);

        // R10 write while active: count kept, levels updated
        wr(16'd9, 8'h33, 8'h44);
        chk("R10 levels", {16'h0, reg_rdata[15:0]}, 32'h3344);
        chk("R10 index shown", {16'h0, reg_rdata[31:16]}, 32'd2);

        // R11 restart mid-transfer
        start_pulse();
        chk("R11 index reset", {16'h0, reg_rdata[31:16]}, 32'd0);
        chk("R11 active", {31'h0, xfer_active}, 32'h1);
        for (int w = 1; w <= 4; w++) begin
            word_pulse();
            chk("R8 index step", {16'h0, reg_rdata[31:16]}, 32'(w));
            chk("R9 no early end", {31'h0, xfer_end}, 32'h0);
        end
        // R9 final word (count 5 proves R10 kept the count)
        word_pulse();
        chk("R9 end pulse", {31'h0, xfer_end}, 32'h1);
        chk("R9 inactive", {31'h0, xfer_active}, 32'h0);
        chk("R10 count kept", {16'h0, reg_rdata[31:16]}, 32'd5);
        step();
        chk("R9 pulse width", {31'h0, xfer_end}, 32'h0);
        word_pulse();
        chk("R9 index holds", {16'h0, reg_rdata[31:16]}, 32'd5);
        chk("R9 no second end", {31'h0, xfer_end}, 32'h0);

        // R12 idle write restores programmed readback
        wr(16'd3, 8'h00, 8'h00);
        chk("R12 idle write", reg_rdata, 32'h0003_0000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule